// File: doc/BRIEF.md
# Narrowing Floating-Point Format Converter

This block turns a 32-bit single-precision binary float into one of four narrower float encodings. The four targets are a 16-bit word with 5 exponent and 10 fraction bits, a 16-bit word with 8 and 7, an 8-bit word with 5 and 2, and an 8-bit word with 4 and 3. The conversion is purely combinational. A two-bit select picks the target, and the result comes out right-aligned in a 16-bit output word.

The converter handles the special values: NaN, infinity and signed zero. It rebiases the exponent and builds subnormal results, including results from single-precision subnormal inputs. When a round-up overflows the fraction, the carry flows into the exponent. A result that grows past the largest finite value saturates to that format's overflow code.

Two rounding modes are offered. The first is round-to-nearest with ties to even. The second is stochastic rounding, which compares the discarded fraction against a pseudo-random draw derived from a caller-supplied 32-bit seed. The stochastic comparison uses exact integer cross-multiplication.

Top module: `narrow_convert`

## Requirements
- R1: `fmt_sel` picks the target: 0 = E5M10 (bias 15), 1 = E8M7 (bias 127), 2 = E5M2 (bias 15), 3 = E4M3 (bias 7). The encoding is {sign, exponent, fraction}, placed in the low bits of `dst_word`, and the unused upper bits are 0.
- R2: Any NaN input, of either sign, gives the positive quiet NaN of the target: 0x7E00, 0x7FC0, 0x007E or 0x007F.
- R3: An infinite input gives the signed infinity of the target (0x7C00, 0x7F80 or 0x007C, with bit 15 or bit 7 carrying the sign). E4M3 has no infinity, so it gives the signed maximum finite value, 0x7E or 0xFE.
- R4: A zero input of either sign gives a zero exponent and zero fraction, with the input sign kept.
- R5: For a normal source, the target exponent is the source exponent minus 127 plus the target bias. A hidden 1 is present exactly when the source exponent field is nonzero. Exactly representable values convert without change.
- R6: When the rebiased exponent is below 1, the output exponent field is 0. The significand is then shifted right by (1 − rebiased exponent) extra places before rounding.
- R7: With `rnd_mode` = 0, rounding is to nearest. A result exactly halfway between two values rounds to the one with an even fraction LSB.
- R8: A round-up of an all-ones fraction clears the fraction and increments the exponent. This includes the step from the largest subnormal to the smallest normal.
- R9: A finite result above the largest finite value becomes the signed overflow code: infinity where the format has one, otherwise the signed maximum finite value.
- R10: With `rnd_mode` = 1, the draw is computed as follows. The seed is shifted right by one, and the XOR of seed bits 0, 1, 3 and 12 is ORed in at bit 15.
- R11: With `rnd_mode` = 1, the result rounds up exactly when discarded × (2^32 − 1) ≥ draw × (2^23 − 1). Here "discarded" is the low (23 − target fraction width) bits of the source fraction. A draw of 0 therefore always rounds up.
- R12: A source with a zero exponent field and a nonzero fraction (a single-precision subnormal) is scaled as if its exponent field were 1, with no hidden bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_word | input | 32 | Single-precision source value |
| fmt_sel | input | 2 | Target format select |
| rnd_mode | input | 1 | 0 = nearest-even, 1 = stochastic |
| seed | input | 32 | Seed for the stochastic draw |
| dst_word | output | 16 | Converted value, right-aligned |

## Verification
The hardest case to reach from the ports is the exact boundary of the stochastic comparison. There, whether a value rounds up depends on a single unit of the discarded fraction and on where the feedback bit lands in the draw. The stimulus picks seeds whose draws can be worked out by hand: seed 2 gives a draw of 0x8001, and seeds 1 and 0x10000 both give 0x8000. Discarded fractions of 64 and 65 then sit on either side of the threshold. Ties at the largest finite values and the carry out of the largest subnormal are driven with hand-built source words. A power-of-two sweep covers every normal and subnormal exponent of each target.

// File: rtl/nconv_pkg.sv
package nconv_pkg;

  localparam int SRC_W    = 32;
  localparam int SRC_EW   = 8;
  localparam int SRC_MW   = 23;
  localparam int SRC_BIAS = 127;
  localparam int NFMT     = 4;
  localparam int DST_W    = 16;

  typedef enum logic [1:0] {
    FMT_E5M10 = 2'd0,
    FMT_E8M7  = 2'd1,
    FMT_E5M2  = 2'd2,
    FMT_E4M3  = 2'd3
  } fmt_e;

  function automatic int fmt_ew(input int idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      2:       return 5;
      default: return 4;
    endcase
  endfunction

  function automatic int fmt_mw(input int idx);
    case (idx)
      0:       return 10;
      1:       return 7;
      2:       return 2;
      default: return 3;
    endcase
  endfunction

  function automatic int fmt_bias(input int idx);
    case (idx)
      0:       return 15;
      1:       return 127;
      2:       return 15;
      default: return 7;
    endcase
  endfunction

  // Only the 4/3 layout reuses the top exponent for finite values.
  function automatic bit fmt_has_inf(input int idx);
    return idx != 3;
  endfunction

  // Pseudo-random draw: shift right, feedback tap lands at bit 15.
  function automatic logic [31:0] sr_draw(input logic [31:0] s);
    logic fb;
    fb = s[0] ^ s[1] ^ s[3] ^ s[12];
    return (s >> 1) | ({31'd0, fb} << 15);
  endfunction

  // Nearest-even decision from guard, sticky and kept LSB.
  function automatic logic rne_round_up(input logic guard, input logic sticky,
                                        input logic lsb);
    return guard & (sticky | lsb);
  endfunction

endpackage

// File: rtl/sr_draw_gen.sv
module sr_draw_gen
  import nconv_pkg::*;
(
  input  logic [SRC_W-1:0] seed_i,
  output logic [SRC_W-1:0] draw_o
);

  always_comb draw_o = sr_draw(seed_i);

  always_comb begin
    assert_draw_shift_R10: assert (draw_o[31] == 1'b0 && draw_o[14:0] == seed_i[15:1]
                                   && draw_o[30:16] == seed_i[31:17])
      else $error("draw does not carry the shifted seed");
  end

endmodule

// File: rtl/stoch_cmp.sv
module stoch_cmp
  import nconv_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]    disc_i,
  input  logic [SRC_W-1:0] draw_i,
  output logic             up_o
);

  localparam logic [63:0] SRC_ONES  = (64'd1 << SRC_MW) - 64'd1;
  localparam logic [63:0] DRAW_ONES = 64'h0000_0000_FFFF_FFFF;

  logic [63:0] lhs;
  logic [63:0] rhs;

  always_comb begin
    lhs  = 64'(disc_i) * DRAW_ONES;
    rhs  = 64'(draw_i) * SRC_ONES;
    up_o = (lhs >= rhs);
  end

  always_comb begin
    if (draw_i == '0)
      assert_zero_draw_up_R11: assert (up_o) else $error("zero draw must round up");
    if (disc_i == '0 && draw_i != '0)
      assert_exact_stays_R11: assert (!up_o) else $error("exact value rounded up");
  end

endmodule

// File: rtl/narrow_core.sv
module narrow_core
  import nconv_pkg::*;
#(
  parameter int EW      = 5,
  parameter int MW      = 10,
  parameter int BIAS    = 15,
  parameter bit HAS_INF = 1'b1,
  parameter bit HAS_NAN = 1'b1
) (
  input  logic [SRC_W-1:0] src_i,
  input  logic             stoch_i,
  input  logic [SRC_W-1:0] draw_i,
  output logic [EW+MW:0]   res_o
);

  localparam int MAGW  = EW + MW;
  localparam int DROP  = SRC_MW - MW;
  localparam int SHMAX = SRC_MW + 10;
  localparam int WW    = SRC_MW + 1 + 32;

  localparam logic [31:0] INF_MAG = ((32'd1 << EW) - 32'd1) << MW;
  localparam logic [31:0] MAX_MAG = HAS_INF ? (INF_MAG - 32'd1)
                                            : (INF_MAG | ((32'd1 << MW) - 32'd2));
  localparam logic [31:0] OVF_MAG = HAS_INF ? INF_MAG : MAX_MAG;
  localparam logic [31:0] NAN_MAG = HAS_INF ? (INF_MAG | (32'd1 << (MW - 1)))
                                            : ((32'd1 << MAGW) - 32'd1);
  localparam logic [MAGW-1:0] NAN_FIELD = HAS_NAN ? NAN_MAG[MAGW-1:0] : MAX_MAG[MAGW-1:0];

  logic              s_sign;
  logic [SRC_EW-1:0] s_exp;
  logic [SRC_MW-1:0] s_frac;
  logic              in_nan, in_inf, in_zero, in_finite;
  int                e_eff, reb, sh;
  logic              is_sub;
  logic [SRC_MW:0]   sig;
  logic [WW-1:0]     wide;
  logic [MW:0]       kept;
  logic              guard, sticky;
  logic [DROP-1:0]   disc;
  logic              st_up, rne_up, round_up;
  logic [31:0]       mag_base, mag_rnd;
  logic              ovf, carry;

  // Source classification and alignment.
  always_comb begin
    s_sign    = src_i[31];
    s_exp     = src_i[30:23];
    s_frac    = src_i[22:0];
    in_nan    = (&s_exp) && (|s_frac);
    in_inf    = (&s_exp) && !(|s_frac);
    in_zero   = !(|s_exp) && !(|s_frac);
    in_finite = !(&s_exp) && !in_zero;
    e_eff     = (s_exp == '0) ? 1 : int'(s_exp);
    reb       = e_eff - SRC_BIAS + BIAS;
    is_sub    = (reb < 1);
    sh        = DROP + (is_sub ? (1 - reb) : 0);
    if (sh > SHMAX) sh = SHMAX;
    sig       = {(s_exp != '0), s_frac};
    wide      = {sig, 32'd0} >> sh;
    kept      = wide[32 +: MW+1];
    guard     = wide[31];
    sticky    = |wide[30:0];
    disc      = s_frac[DROP-1:0];
  end

  stoch_cmp #(.DW(DROP)) u_stoch (
    .disc_i (disc),
    .draw_i (draw_i),
    .up_o   (st_up)
  );

  // Rounding and packing.
  always_comb begin
    rne_up   = rne_round_up(guard, sticky, kept[0]);
    round_up = stoch_i ? st_up : rne_up;
    mag_base = is_sub ? 32'(kept) : ((32'(reb - 1) << MW) + 32'(kept));
    mag_rnd  = mag_base + {31'd0, round_up};
    ovf      = (mag_rnd > MAX_MAG);
    carry    = round_up && ((mag_rnd >> MW) != (mag_base >> MW));
  end

  generate
    if (HAS_NAN) begin : g_nan
      always_comb begin
        if (in_nan)       res_o = {1'b0, NAN_FIELD};
        else if (in_inf)  res_o = {s_sign, OVF_MAG[MAGW-1:0]};
        else if (in_zero) res_o = {s_sign, {MAGW{1'b0}}};
        else if (ovf)     res_o = {s_sign, OVF_MAG[MAGW-1:0]};
        else              res_o = {s_sign, mag_rnd[MAGW-1:0]};
      end
    end else begin : g_nonan
      always_comb begin
        if (in_nan)                 res_o = {1'b0, MAX_MAG[MAGW-1:0]};
        else if (in_inf || ovf)     res_o = {s_sign, OVF_MAG[MAGW-1:0]};
        else if (in_zero)           res_o = {s_sign, {MAGW{1'b0}}};
        else                        res_o = {s_sign, mag_rnd[MAGW-1:0]};
      end
    end
  endgenerate

  always_comb begin
    if (in_zero)
      assert_zero_sign_R4: assert (res_o == {s_sign, {MAGW{1'b0}}})
        else $error("zero lost or sign changed");
    if (!in_nan)
      assert_no_false_nan_R2: assert (!((res_o[MAGW-1:MW] == {EW{1'b1}}) &&
                                        (HAS_INF ? (res_o[MW-1:0] != '0)
                                                 : (res_o[MW-1:0] == {MW{1'b1}}))))
        else $error("non-NaN input produced a NaN code");
    if (in_finite)
      assert_mag_bound_R9: assert (32'(res_o[MAGW-1:0]) <= OVF_MAG)
        else $error("finite result above overflow code");
    if (in_finite && !stoch_i && guard && !sticky && !ovf)
      assert_tie_even_R7: assert (res_o[0] == 1'b0) else $error("tie not resolved to even");
    if (in_finite && is_sub && !round_up)
      assert_sub_exp_R6: assert (res_o[MAGW-1:MW] == '0) else $error("subnormal exponent nonzero");
    if (in_finite && carry && !ovf)
      assert_carry_clear_R8: assert (res_o[MW-1:0] == '0) else $error("carry left fraction set");
  end

endmodule

// File: rtl/narrow_convert.sv
module narrow_convert
  import nconv_pkg::*;
(
  input  logic [31:0] src_word,
  input  logic [1:0]  fmt_sel,
  input  logic        rnd_mode,
  input  logic [31:0] seed,
  output logic [15:0] dst_word
);

  logic [SRC_W-1:0] draw;
  logic [DST_W-1:0] lane [NFMT];

  sr_draw_gen u_draw (
    .seed_i (seed),
    .draw_o (draw)
  );

  generate
    for (genvar g = 0; g < NFMT; g++) begin : g_fmt
      localparam int GEW = fmt_ew(g);
      localparam int GMW = fmt_mw(g);
      logic [GEW+GMW:0] res;

      narrow_core #(
        .EW      (GEW),
        .MW      (GMW),
        .BIAS    (fmt_bias(g)),
        .HAS_INF (fmt_has_inf(g)),
        .HAS_NAN (1'b1)
      ) u_core (
        .src_i   (src_word),
        .stoch_i (rnd_mode),
        .draw_i  (draw),
        .res_o   (res)
      );

      assign lane[g] = DST_W'(res);
    end
  endgenerate

  always_comb dst_word = lane[fmt_sel];

  always_comb begin
    assert_right_aligned_R1: assert ((dst_word >> (1 + fmt_ew(int'(fmt_sel)) +
                                                   fmt_mw(int'(fmt_sel)))) == '0)
      else $error("bits above the selected width are set");
  end

endmodule

// File: tb/test_narrow_convert.sv
`timescale 1ns/1ps
module test_narrow_convert;

  typedef struct packed {
    logic [31:0] src;
    logic [1:0]  fmt;
    logic        mode;
    logic [31:0] seed;
    logic [15:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 56;
  localparam vec_t VECS [NV] = '{
    '{32'h3F800000, 2'd0, 1'b0, 32'h0, 16'h3C00, 8'd5},  // R5
    '{32'h3F800000, 2'd1, 1'b0, 32'h0, 16'h3F80, 8'd5},
    '{32'h3F800000, 2'd2, 1'b0, 32'h0, 16'h003C, 8'd1},  // R1
    '{32'h3F800000, 2'd3, 1'b0, 32'h0, 16'h0038, 8'd5},
    '{32'hC0000000, 2'd0, 1'b0, 32'h0, 16'hC000, 8'd5},
    '{32'hC0000000, 2'd3, 1'b0, 32'h0, 16'h00C0, 8'd5},
    '{32'h00000000, 2'd0, 1'b0, 32'h0, 16'h0000, 8'd4},  // R4
    '{32'h80000000, 2'd0, 1'b0, 32'h0, 16'h8000, 8'd4},
    '{32'h80000000, 2'd3, 1'b0, 32'h0, 16'h0080, 8'd4},
    '{32'h7F800000, 2'd0, 1'b0, 32'h0, 16'h7C00, 8'd3},  // R3
    '{32'h7F800000, 2'd1, 1'b0, 32'h0, 16'h7F80, 8'd3},
    '{32'h7F800000, 2'd2, 1'b0, 32'h0, 16'h007C, 8'd3},
    '{32'hFF800000, 2'd2, 1'b0, 32'h0, 16'h00FC, 8'd3},
    '{32'h7F800000, 2'd3, 1'b0, 32'h0, 16'h007E, 8'd3},
    '{32'hFF800000, 2'd3, 1'b0, 32'h0, 16'h00FE, 8'd3},
    '{32'h7FC00000, 2'd0, 1'b0, 32'h0, 16'h7E00, 8'd2},  // R2
    '{32'h7FC00000, 2'd1, 1'b0, 32'h0, 16'h7FC0, 8'd2},
    '{32'h7FC00000, 2'd2, 1'b0, 32'h0, 16'h007E, 8'd2},
    '{32'h7FC00000, 2'd3, 1'b0, 32'h0, 16'h007F, 8'd2},
    '{32'hFFC00001, 2'd0, 1'b0, 32'h0, 16'h7E00, 8'd2},
    '{32'h3F808000, 2'd1, 1'b0, 32'h0, 16'h3F80, 8'd7},  // R7
    '{32'h3F818000, 2'd1, 1'b0, 32'h0, 16'h3F82, 8'd7},
    '{32'h3F808001, 2'd1, 1'b0, 32'h0, 16'h3F81, 8'd7},
    '{32'h3F900000, 2'd2, 1'b0, 32'h0, 16'h003C, 8'd7},
    '{32'h3FB00000, 2'd2, 1'b0, 32'h0, 16'h003E, 8'd7},
    '{32'h3FA00000, 2'd2, 1'b0, 32'h0, 16'h003D, 8'd5},
    '{32'h3FFFFFFF, 2'd1, 1'b0, 32'h0, 16'h4000, 8'd8},  // R8
    '{32'h387FE000, 2'd0, 1'b0, 32'h0, 16'h0400, 8'd8},
    '{32'h477FE000, 2'd0, 1'b0, 32'h0, 16'h7BFF, 8'd9},  // R9
    '{32'h477FF000, 2'd0, 1'b0, 32'h0, 16'h7C00, 8'd9},
    '{32'h477FEFFF, 2'd0, 1'b0, 32'h0, 16'h7BFF, 8'd9},
    '{32'h501502F9, 2'd0, 1'b0, 32'h0, 16'h7C00, 8'd9},
    '{32'h501502F9, 2'd3, 1'b0, 32'h0, 16'h007E, 8'd9},
    '{32'hD01502F9, 2'd3, 1'b0, 32'h0, 16'h00FE, 8'd9},
    '{32'h43E00000, 2'd3, 1'b0, 32'h0, 16'h007E, 8'd9},
    '{32'h43E80000, 2'd3, 1'b0, 32'h0, 16'h007E, 8'd7},
    '{32'h43F00000, 2'd3, 1'b0, 32'h0, 16'h007E, 8'd9},
    '{32'h33800000, 2'd0, 1'b0, 32'h0, 16'h0001, 8'd6},  // R6
    '{32'h33000000, 2'd0, 1'b0, 32'h0, 16'h0000, 8'd6},
    '{32'h33400000, 2'd0, 1'b0, 32'h0, 16'h0001, 8'd6},
    '{32'h38000000, 2'd0, 1'b0, 32'h0, 16'h0200, 8'd6},
    '{32'h00000001, 2'd1, 1'b0, 32'h0, 16'h0000, 8'd12}, // R12
    '{32'h80000001, 2'd1, 1'b0, 32'h0, 16'h8000, 8'd12},
    '{32'h00400000, 2'd1, 1'b0, 32'h0, 16'h0040, 8'd12},
    '{32'h00008000, 2'd1, 1'b0, 32'h0, 16'h0000, 8'd12},
    '{32'h00018000, 2'd1, 1'b0, 32'h0, 16'h0002, 8'd12},
    '{32'h3F800040, 2'd1, 1'b1, 32'h00000002, 16'h3F80, 8'd11}, // R11 draw 0x8001
    '{32'h3F800041, 2'd1, 1'b1, 32'h00000002, 16'h3F81, 8'd11},
    '{32'h3F800040, 2'd1, 1'b1, 32'h00010000, 16'h3F81, 8'd10}, // R10 draw 0x8000
    '{32'h3F800040, 2'd1, 1'b1, 32'h00000001, 16'h3F81, 8'd10},
    '{32'h3F800000, 2'd1, 1'b1, 32'h00000000, 16'h3F81, 8'd11},
    '{32'h3F80FFFF, 2'd1, 1'b1, 32'hFFFFFFFF, 16'h3F80, 8'd11},
    '{32'h3FFF0041, 2'd1, 1'b1, 32'h00000002, 16'h4000, 8'd8},
    '{32'h3F808000, 2'd1, 1'b1, 32'h00000002, 16'h3F81, 8'd11},
    '{32'h7F800000, 2'd1, 1'b1, 32'h00000000, 16'h7F80, 8'd3},
    '{32'h3F808000, 2'd1, 1'b1, 32'hFFFFFFFF, 16'h3F80, 8'd11}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] src_word = '0;
  logic [1:0]  fmt_sel = '0;
  logic        rnd_mode = 1'b0;
  logic [31:0] seed = '0;
  logic [15:0] dst_word;

  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  narrow_convert i_narrow_convert (
    .src_word (src_word),
    .fmt_sel  (fmt_sel),
    .rnd_mode (rnd_mode),
    .seed     (seed),
    .dst_word (dst_word)
  );

  task automatic drive(input logic [31:0] s, input logic [1:0] f, input logic m,
                       input logic [31:0] sd);
    @(posedge clk);
    #1;
    src_word = s;
    fmt_sel  = f;
    rnd_mode = m;
    seed     = sd;
    @(negedge clk);
  endtask

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input int req,
                       input logic [31:0] s, input logic [1:0] f);
    applied++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL R%0d src=%08h fmt=%0d got=%04h expected=%04h", req, s, f, got, exp);
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    int ew, mw, bias, emax;
    logic [31:0] s;
    logic [15:0] e;
    // R4: output during reset with quiet inputs.
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dst_word, 16'h0000, 4, src_word, fmt_sel);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].src, VECS[i].fmt, VECS[i].mode, VECS[i].seed);
      check(dst_word, VECS[i].exp, int'(VECS[i].req), VECS[i].src, VECS[i].fmt);
    end

    // R5 and R6: every power of two in range of each target.
    for (int f = 0; f < 4; f++) begin
      ew   = (f == 1) ? 8 : ((f == 3) ? 4 : 5);
      mw   = (f == 0) ? 10 : ((f == 1) ? 7 : ((f == 2) ? 2 : 3));
      bias = (1 << (ew - 1)) - 1;
      emax = (f == 3) ? 15 : ((1 << ew) - 2);
      for (int k = 1 - bias - mw; k <= emax - bias; k++) begin
        if (k >= -126) s = 32'(k + 127) << 23;
        else           s = 32'd1 << (k + 149);
        if (k >= 1 - bias) e = 16'(32'(k + bias) << mw);   // R5 normal
        else               e = 16'(32'd1 << (k + bias + mw - 1)); // R6 subnormal
        drive(s, 2'(f), 1'b0, 32'h0);
        check(dst_word, e, (k >= 1 - bias) ? 5 : 6, s, 2'(f));
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule